// File: doc/BRIEF.md
# Four-State Logic-in-Memory Cell Array

This block models, cycle by cycle, an array of multilevel cells in which every cell holds a stored memory bit and a logic bit at the same time. The two bits make up a 2-bit cell state: the upper bit is the memory value, which logic work never alters, and the lower bit is the logic value. States 11 and 01 are the absolute states. A logic step can only drop the lower bit from 1 to 0, which gives 10 or 00. The default array is 64 rows of 64 cells, and every cell of the addressed row works in parallel.

The controller takes one row-wide command per cycle. The basic commands are row program, memory read, logic read, NAND with two operand vectors, and refresh. The composite commands NOT, AND and XOR are broken into a fixed sequence of NAND cell steps and internal row reads. Each NAND step refreshes its row first: any cell whose logic bit is 0 is restored to its absolute state before the NAND is applied. Three running counters report switching events, refreshed cells and row reads. While a composite command is running, a busy flag is high and the controller refuses any new command.

Top module: `lim_cell_array`

## Requirements
- R1: After reset every cell is in state 01 (memory 0, logic 1), all three counters are zero, and busy and rd_valid are low.
- R2: Op code 0 (program) loads opa into the memory bits of cmd_row and sets every logic bit of that row to 1. Op code 1 (memory read) returns the memory bits of cmd_row on rd_data, with rd_valid high, in the cycle after acceptance. Op code 2 (logic read) returns the logic bits in the same way.
- R3: Op code 3 (NAND) sets each logic bit of cmd_row to NOT(opa AND opb) for that cell, and it completes in the accepting cycle.
- R4: Every NAND step refreshes its row first. The refreshed-cell counter goes up by the number of cells in that row whose logic bit was 0. Op code 4 (refresh) sets all logic bits of cmd_row to 1 and counts the refreshed cells the same way.
- R5: Op code 5 (NOT) writes NOT opa into row r. Busy stays high for 1 cycle, and rd_valid then returns NOT opa.
- R6: Op code 6 (AND) runs a NAND in row r, reads it back, then runs a NOT in row r+1 (modulo the row count). Busy stays high for 3 cycles, and rd_valid then returns opa AND opb.
- R7: Op code 7 (XOR) uses rows r to r+3 (modulo the row count) with 3 compute cycles and 4 reads. Rows r+1 and r+2 are computed in the same cycle. Busy stays high for 6 cycles, and rd_valid then returns opa XOR opb.
- R8: A command presented while busy is high is ignored: no row changes and no counter moves.
- R9: The switch-event counter goes up by the number of cells with both operands 1 in each NAND step. The read counter goes up by one for every row read, external or internal to a composite command.
- R10: No command other than program changes any memory bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command present |
| cmd_op | input | 3 | Command code (0 program .. 7 XOR) |
| cmd_row | input | 6 | Addressed row |
| opa | input | 64 | Operand a / program data |
| opb | input | 64 | Operand b |
| busy | output | 1 | Composite command in progress |
| rd_valid | output | 1 | rd_data holds a read or composite result |
| rd_data | output | 64 | Read or composite result row |
| sw_cnt | output | 32 | Switching events |
| rf_cnt | output | 32 | Refreshed cells |
| rd_cnt | output | 32 | Row reads |

## Verification
The assertions assume that the counters never wrap. They also assume that the row count is at least four and a power of two, so that the rows of an XOR sequence are distinct. The stimulus keeps within this by running a few hundred commands, far below counter overflow, on the default 64-row array. Random operands and rows are mixed with directed cases: row wrap-around for AND and XOR, commands issued during busy, and repeated NAND steps on a row that has already been cleared. A final memory read of every row confirms that logic work left the memory bits untouched.

// File: rtl/lim_cell_array.sv
module lim_cell_array #(
  parameter int ROWS = 64,
  parameter int COLS = 64,
  parameter int CW   = 32,
  localparam int AW  = $clog2(ROWS)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cmd_valid,
  input  logic [2:0]      cmd_op,
  input  logic [AW-1:0]   cmd_row,
  input  logic [COLS-1:0] opa,
  input  logic [COLS-1:0] opb,
  output logic            busy,
  output logic            rd_valid,
  output logic [COLS-1:0] rd_data,
  output logic [CW-1:0]   sw_cnt,
  output logic [CW-1:0]   rf_cnt,
  output logic [CW-1:0]   rd_cnt
);
  localparam logic [2:0] OP_PROG = 3'd0, OP_MRD = 3'd1, OP_LRD = 3'd2, OP_NAND = 3'd3,
                         OP_REF = 3'd4, OP_NOT = 3'd5, OP_AND = 3'd6, OP_XOR = 3'd7;

  logic [COLS-1:0] mbits [ROWS];
  logic [COLS-1:0] lbits [ROWS];

  logic [2:0]      step, sop, last;
  logic [AW-1:0]   srow;
  logic [COLS-1:0] sa, sb, buf1, buf2, buf3;

  logic            w0_en, w1_en, rp_en, rp_mem;
  logic [AW-1:0]   w0_row, w1_row, rp_row;
  logic [COLS-1:0] w0_a, w0_b, w1_a, w1_b;
  logic [1:0]      rp_dst;

  function automatic logic [CW-1:0] ones_in(input logic [COLS-1:0] v);
    logic [CW-1:0] n;
    n = '0;
    for (int i = 0; i < COLS; i++) n = n + CW'(v[i]);
    return n;
  endfunction

  assign busy = (step != 3'd0);
  wire acc     = cmd_valid && !busy;
  wire wr_fire = acc && (cmd_op == OP_PROG);
  assign last  = (sop == OP_NOT) ? 3'd1 : (sop == OP_AND) ? 3'd3 : 3'd6;

  always_comb begin
    w0_en = 1'b0; w0_row = srow; w0_a = '0; w0_b = '0;
    w1_en = 1'b0; w1_row = srow; w1_a = '0; w1_b = '0;
    rp_en = 1'b0; rp_row = srow; rp_mem = 1'b0; rp_dst = 2'd0;
    if (acc) begin
      case (cmd_op)
        OP_MRD:  begin rp_en = 1'b1; rp_row = cmd_row; rp_mem = 1'b1; end
        OP_LRD:  begin rp_en = 1'b1; rp_row = cmd_row; end
        OP_NAND, OP_AND, OP_XOR: begin w0_en = 1'b1; w0_row = cmd_row; w0_a = opa; w0_b = opb; end
        OP_REF:  begin w0_en = 1'b1; w0_row = cmd_row; end
        OP_NOT:  begin w0_en = 1'b1; w0_row = cmd_row; w0_a = opa; w0_b = '1; end
        default: ;
      endcase
    end else if (busy) begin
      case (sop)
        OP_NOT: rp_en = 1'b1;
        OP_AND: begin
          case (step)
            3'd1: begin rp_en = 1'b1; rp_dst = 2'd1; end
            3'd2: begin w0_en = 1'b1; w0_row = srow + AW'(1); w0_a = buf1; w0_b = '1; end
            default: begin rp_en = 1'b1; rp_row = srow + AW'(1); end
          endcase
        end
        default: begin
          case (step)
            3'd1: begin rp_en = 1'b1; rp_dst = 2'd1; end
            3'd2: begin
              w0_en = 1'b1; w0_row = srow + AW'(1); w0_a = sa; w0_b = buf1;
              w1_en = 1'b1; w1_row = srow + AW'(2); w1_a = sb; w1_b = buf1;
            end
            3'd3: begin rp_en = 1'b1; rp_row = srow + AW'(1); rp_dst = 2'd2; end
            3'd4: begin rp_en = 1'b1; rp_row = srow + AW'(2); rp_dst = 2'd3; end
            3'd5: begin w0_en = 1'b1; w0_row = srow + AW'(3); w0_a = buf2; w0_b = buf3; end
            default: begin rp_en = 1'b1; rp_row = srow + AW'(3); end
          endcase
        end
      endcase
    end
  end

  wire [CW-1:0] sw_inc = (w0_en ? ones_in(w0_a & w0_b) : '0) + (w1_en ? ones_in(w1_a & w1_b) : '0);
  wire [CW-1:0] rf_inc = (w0_en ? ones_in(~lbits[w0_row]) : '0) + (w1_en ? ones_in(~lbits[w1_row]) : '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < ROWS; i++) begin
        mbits[i] <= '0;
        lbits[i] <= '1;
      end
      step <= 3'd0; sop <= OP_NOT; srow <= '0;
      sa <= '0; sb <= '0; buf1 <= '0; buf2 <= '0; buf3 <= '0;
      rd_valid <= 1'b0; rd_data <= '0;
      sw_cnt <= '0; rf_cnt <= '0; rd_cnt <= '0;
    end else begin
      if (acc && cmd_op >= OP_NOT) begin
        step <= 3'd1; sop <= cmd_op; srow <= cmd_row; sa <= opa; sb <= opb;
      end else if (busy) begin
        step <= (step == last) ? 3'd0 : step + 3'd1;
      end
      if (wr_fire) begin
        mbits[cmd_row] <= opa;
        lbits[cmd_row] <= '1;
      end
      if (w0_en) lbits[w0_row] <= ~(w0_a & w0_b);
      if (w1_en) lbits[w1_row] <= ~(w1_a & w1_b);
      rd_valid <= rp_en && (rp_dst == 2'd0);
      if (rp_en) begin
        case (rp_dst)
          2'd0: rd_data <= rp_mem ? mbits[rp_row] : lbits[rp_row];
          2'd1: buf1 <= lbits[rp_row];
          2'd2: buf2 <= lbits[rp_row];
          default: buf3 <= lbits[rp_row];
        endcase
        rd_cnt <= rd_cnt + CW'(1);
      end
      sw_cnt <= sw_cnt + sw_inc;
      rf_cnt <= rf_cnt + rf_inc;
    end
  end

  // R3
  nand_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(w0_en) |-> ((lbits[$past(w0_row)] & $past(w0_a & w0_b)) == '0));

  // R10
  mem_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(wr_fire) |-> (mbits[$past(cmd_row)] == $past(mbits[cmd_row])));

  // R7
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && $past(busy)) |-> !busy);

  // R4
  refresh_mono_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rf_cnt >= $past(rf_cnt));

  // R9
  sw_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_cnt - $past(sw_cnt)) <= CW'(2 * COLS));

  // R8
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(busy) && busy) |-> (srow == $past(srow)));
endmodule

// File: tb/lim_cell_array_test.sv
`timescale 1ns/1ps
module lim_cell_array_test;
  localparam int ROWS = 64, COLS = 64, CW = 32, AW = 6;

  logic clk = 1'b0, rst_n = 1'b0, cmd_valid = 1'b0;
  logic [2:0] cmd_op = '0;
  logic [AW-1:0] cmd_row = '0;
  logic [COLS-1:0] opa = '0, opb = '0;
  logic busy, rd_valid;
  logic [COLS-1:0] rd_data;
  logic [CW-1:0] sw_cnt, rf_cnt, rd_cnt;

  lim_cell_array uut (.clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_row(cmd_row), .opa(opa), .opb(opb), .busy(busy), .rd_valid(rd_valid),
    .rd_data(rd_data), .sw_cnt(sw_cnt), .rf_cnt(rf_cnt), .rd_cnt(rd_cnt));

  always #2 clk = ~clk;

  int checks = 0, fails = 0;
  logic [COLS-1:0] mm [ROWS];
  logic [COLS-1:0] ll [ROWS];
  int swm = 0, rfm = 0, rdm = 0;

  task automatic chk(input string req, input logic [COLS-1:0] act, input logic [COLS-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic mstep(input int r, input logic [COLS-1:0] a, input logic [COLS-1:0] b);
    rfm += $countones(~ll[r % ROWS]);
    swm += $countones(a & b);
    ll[r % ROWS] = ~(a & b);
  endtask

  task automatic send(input logic [2:0] op, input int r, input logic [COLS-1:0] a, input logic [COLS-1:0] b);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_row = AW'(r); opa = a; opb = b;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic wait_idle(input string req, input int exp_n);
    int n = 0;
    while (busy && n < 20) begin @(negedge clk); n++; end
    chk(req, COLS'(n), COLS'(exp_n));
  endtask

  task automatic run(input logic [2:0] op, input int r, input logic [COLS-1:0] a, input logic [COLS-1:0] b);
    logic [COLS-1:0] n1, n2, n3;
    send(op, r, a, b);
    case (op)
      3'd0: begin mm[r] = a; ll[r] = '1; end
      3'd1: begin rdm++; chk("R2 mread", rd_valid ? rd_data : 'x, mm[r]); end
      3'd2: begin rdm++; chk("R2 lread", rd_valid ? rd_data : 'x, ll[r]); end
      3'd3: mstep(r, a, b);
      3'd4: mstep(r, '0, '0);
      3'd5: begin
        mstep(r, a, '1); rdm++;
        wait_idle("R5 busy", 1);
        chk("R5 not", rd_valid ? rd_data : 'x, ~a);
      end
      3'd6: begin
        mstep(r, a, b); rdm++; n1 = ll[r];
        mstep(r + 1, n1, '1); rdm++;
        wait_idle("R6 busy", 3);
        chk("R6 and", rd_valid ? rd_data : 'x, a & b);
      end
      default: begin
        mstep(r, a, b); rdm++; n1 = ll[r];
        mstep(r + 1, a, n1); mstep(r + 2, b, n1); rdm += 2;
        n2 = ll[(r + 1) % ROWS]; n3 = ll[(r + 2) % ROWS];
        mstep(r + 3, n2, n3); rdm++;
        wait_idle("R7 busy", 6);
        chk("R7 xor", rd_valid ? rd_data : 'x, a ^ b);
      end
    endcase
  endtask

  function automatic logic [COLS-1:0] rnd64();
    return {$urandom(), $urandom()};
  endfunction

  task automatic finish_up();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #(4 * 200000);
    fails++;
    $display("FAIL watchdog actual=hang expected=completion");
    finish_up();
  end

  initial begin
    logic [COLS-1:0] a, b;
    void'($urandom(32'd1234));
    for (int i = 0; i < ROWS; i++) begin mm[i] = '0; ll[i] = '1; end
    #9 rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 busy", COLS'(busy), 0);
    chk("R1 rd_valid", COLS'(rd_valid), 0);
    chk("R1 counters", COLS'(sw_cnt + rf_cnt + rd_cnt), 0);
    run(3'd2, 5, '0, '0);
    chk("R1 logic ones", rd_data, '1);
    run(3'd1, 5, '0, '0);
    chk("R1 memory zero", rd_data, '0);

    // R2 program every row
    for (int i = 0; i < ROWS; i++) run(3'd0, i, rnd64(), '0);
    run(3'd1, 0, '0, '0);
    run(3'd1, 63, '0, '0);
    run(3'd2, 63, '0, '0);

    // R3 and R4 directed
    a = 64'hFFFF_0000_FFFF_0000;
    run(3'd3, 3, '1, a);
    run(3'd2, 3, '0, '0);
    chk("R3 nand", rd_data, ~a);
    run(3'd3, 3, 64'h00FF_00FF_00FF_00FF, '1);
    run(3'd2, 3, '0, '0);
    chk("R4 auto refresh", rd_data, 64'hFF00_FF00_FF00_FF00);
    run(3'd4, 3, '0, '0);
    run(3'd2, 3, '0, '0);
    chk("R4 refresh row", rd_data, '1);
    chk("R4 refresh count", COLS'(rf_cnt), COLS'(rfm));

    // R5 R6 R7 directed, with wrap
    run(3'd5, 10, 64'h1234_5678_9ABC_DEF0, '0);
    run(3'd6, 63, 64'hF0F0_F0F0_0F0F_0F0F, 64'hFF00_FF00_FF00_FF00);
    run(3'd2, 63, '0, '0);
    run(3'd7, 62, 64'hAAAA_5555_CCCC_3333, 64'h0F0F_F0F0_3C3C_C3C3);
    run(3'd2, 1, '0, '0);

    // R8 commands during busy are ignored
    send(3'd7, 20, '1, '0);
    mstep(20, '1, '0); rdm++;
    mstep(21, '1, ll[20]); mstep(22, '0, ll[20]); rdm += 2;
    mstep(23, ll[21], ll[22]); rdm++;
    cmd_valid = 1'b1; cmd_op = 3'd0; cmd_row = AW'(40); opa = ~mm[40];
    @(negedge clk);
    cmd_op = 3'd3; opa = '1; opb = '1;
    @(negedge clk);
    cmd_valid = 1'b0;
    wait_idle("R8 busy", 4);
    chk("R8 xor result", rd_valid ? rd_data : 'x, '1);
    run(3'd1, 40, '0, '0);
    run(3'd2, 40, '0, '0);
    chk("R8 counters", COLS'(sw_cnt), COLS'(swm));

    // random mix
    for (int k = 0; k < 400; k++) begin
      int r;
      logic [2:0] op;
      r = int'($urandom_range(0, ROWS - 1));
      op = 3'($urandom_range(1, 7));
      a = rnd64(); b = rnd64();
      if ($urandom_range(0, 3) == 0) b = a;
      run(op, r, a, b);
    end

    // R10 memory preserved
    for (int i = 0; i < ROWS; i++) run(3'd1, i, '0, '0);
    // R9 and R4 counters
    chk("R9 switch count", COLS'(sw_cnt), COLS'(swm));
    chk("R9 read count", COLS'(rd_cnt), COLS'(rdm));
    chk("R4 refresh total", COLS'(rf_cnt), COLS'(rfm));
    chk("R10 no busy", COLS'(busy), 0);
    finish_up();
  end
endmodule